// File: doc/BRIEF.md
# Fused Multiply-Add NaN Resolver

This block is the special-value stage of a single-precision fused multiply-add that computes `acc + a*b`. It inspects the three 32-bit IEEE-754 operands and decides whether the result is fixed by NaN propagation or by an invalid infinity-times-zero product. In either case it raises a valid flag and supplies the 32-bit result and an invalid-operation flag. The main datapath computes the product without rounding and adds it to `acc` with a single final rounding. It uses the output of this stage only when the valid flag is high. The NaN results and flags do not depend on the rounding mode, so this stage has no rounding-mode input.

A static mode input selects one of two conventions.

- **Quieting convention (mode 0):** NaNs are ranked accumulator, then b, then a. A signalling NaN in any operand raises the invalid flag, and the chosen NaN is returned in quiet form.
- **Pass-through convention (mode 1):** NaNs are ranked a, then b, then accumulator. They are returned bit-for-bit and never raise a flag.

The stage is purely combinational. Its outputs follow the operands and the mode within the same cycle.

Top module: `fma_nan_resolver`

## Requirements
- R1: When no operand is a NaN and the product is not infinity times zero, `special_o` and `invalid_o` are low and `result_o` is 0. This holds for ordinary operands, such as acc=0xbf800002 and a=b=0x3f800001.
- R2: With `mode_i`=0, when one or more operands are NaN, the result comes from the first NaN in the order acc, b, a.
- R3: With `mode_i`=1, when one or more operands are NaN, the result comes from the first NaN in the order a, b, acc.
- R4: With `mode_i`=0, a signalling NaN in any operand sets `invalid_o`. This holds even when that NaN is not the one selected. The returned NaN has fraction bit 22 set, and its sign and other payload bits are unchanged.
- R5: With `mode_i`=1, a selected signalling NaN is returned unchanged and `invalid_o` stays low for every input.
- R6: When one multiplicand is an infinity, the other is a zero of either sign, and acc is not a NaN, the result is 0x7FC00000. `invalid_o` is high in mode 0 and low in mode 1.
- R7: When the product is infinity times zero and acc is a NaN, the result is acc. In mode 0 the result is quieted and `invalid_o` is set. In mode 1 the result is acc bit-for-bit and no flag is raised.
- R8: A NaN is an operand with exponent 0xFF and a nonzero fraction. Fraction bit 22 marks it quiet, and bit 22 clear marks it signalling. Infinities (fraction 0) and zeros are not NaNs. An infinity or a zero that does not form an infinity-times-zero product leaves `special_o` low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| mode_i | input | 1 | 0: quieting convention, 1: pass-through convention |
| acc_i | input | 32 | Addend operand |
| mul_a_i | input | 32 | Multiplicand a |
| mul_b_i | input | 32 | Multiplicand b |
| special_o | output | 1 | Result is fixed by this stage |
| result_o | output | 32 | Special result, 0 when `special_o` is low |
| invalid_o | output | 1 | Invalid-operation flag |

## Verification
Every result of this stage is due in the same cycle its operands are applied, with zero register delay. The bench changes the operands and the mode just after a rising clock edge and samples all three outputs at the following falling edge, half a cycle later. Each scenario task applies one operand set per cycle. It checks the output before the next set is driven, so the result observed always belongs to the operands that produced it.

// File: rtl/fma_nan_resolver.sv
module fma_nan_resolver #(
  parameter logic [31:0] DEFAULT_NAN = 32'h7FC0_0000
) (
  input  logic        mode_i,
  input  logic [31:0] acc_i,
  input  logic [31:0] mul_a_i,
  input  logic [31:0] mul_b_i,
  output logic        special_o,
  output logic [31:0] result_o,
  output logic        invalid_o
);
  localparam int QBIT = 22;

  logic acc_nan, a_nan, b_nan;
  logic acc_snan, a_snan, b_snan;
  logic a_inf, b_inf, a_zero, b_zero;
  logic any_nan, any_snan, inf_times_zero;
  logic [31:0] chosen;

  assign acc_nan = (&acc_i[30:23])   & (|acc_i[22:0]);
  assign a_nan   = (&mul_a_i[30:23]) & (|mul_a_i[22:0]);
  assign b_nan   = (&mul_b_i[30:23]) & (|mul_b_i[22:0]);

  assign acc_snan = acc_nan & ~acc_i[QBIT];
  assign a_snan   = a_nan   & ~mul_a_i[QBIT];
  assign b_snan   = b_nan   & ~mul_b_i[QBIT];

  assign a_inf  = (&mul_a_i[30:23]) & ~(|mul_a_i[22:0]);
  assign b_inf  = (&mul_b_i[30:23]) & ~(|mul_b_i[22:0]);
  assign a_zero = ~(|mul_a_i[30:0]);
  assign b_zero = ~(|mul_b_i[30:0]);

  assign any_nan        = acc_nan | a_nan | b_nan;
  assign any_snan       = acc_snan | a_snan | b_snan;
  assign inf_times_zero = (a_inf & b_zero) | (a_zero & b_inf);

  always_comb begin
    chosen = DEFAULT_NAN;
    if (mode_i) begin
      if (a_nan)        chosen = mul_a_i;
      else if (b_nan)   chosen = mul_b_i;
      else if (acc_nan) chosen = acc_i;
    end else begin
      if (acc_nan)      chosen = acc_i;
      else if (b_nan)   chosen = mul_b_i;
      else if (a_nan)   chosen = mul_a_i;
    end
  end

  always_comb begin
    result_o = '0;
    if (any_nan) begin
      result_o = chosen;
      if (!mode_i) result_o[QBIT] = 1'b1;
    end else if (inf_times_zero) begin
      result_o = DEFAULT_NAN;
    end
  end

  assign special_o = any_nan | inf_times_zero;
  assign invalid_o = ~mode_i & (any_snan | inf_times_zero);
endmodule

// File: rtl/fma_nan_resolver_chk.sv
module fma_nan_resolver_chk (
  input logic        mode_i,
  input logic [31:0] acc_i,
  input logic [31:0] mul_a_i,
  input logic [31:0] mul_b_i,
  input logic        special_o,
  input logic [31:0] result_o,
  input logic        invalid_o
);
  function automatic logic nan_f(input logic [31:0] v);
    return (v[30:23] == 8'hFF) && (v[22:0] != 23'd0);
  endfunction
  function automatic logic snan_f(input logic [31:0] v);
    return nan_f(v) && !v[22];
  endfunction
  function automatic logic izp_f(input logic [31:0] x, input logic [31:0] y);
    return (x[30:0] == 31'h7F80_0000) && (y[30:0] == 31'd0);
  endfunction

  logic some_nan, some_snan, izp;
  assign some_nan  = nan_f(acc_i) || nan_f(mul_a_i) || nan_f(mul_b_i);
  assign some_snan = snan_f(acc_i) || snan_f(mul_a_i) || snan_f(mul_b_i);
  assign izp       = izp_f(mul_a_i, mul_b_i) || izp_f(mul_b_i, mul_a_i);

  always_comb begin
    // R1
    no_spurious_special_chk: assert (some_nan || izp || (!special_o && !invalid_o && result_o == 32'd0));
    // R5
    no_passthru_invalid_chk: assert (!mode_i || !invalid_o);
    // R4
    snan_raises_invalid_chk: assert (mode_i || !some_snan || invalid_o);
    // R4
    quiet_output_chk: assert (mode_i || !special_o || result_o[22]);
    // R2
    special_is_nan_chk: assert (!special_o || nan_f(result_o));
    // R6
    invalid_needs_cause_chk: assert (!invalid_o || some_snan || izp);
  end
endmodule

bind fma_nan_resolver fma_nan_resolver_chk i_chk (.*);

// File: tb/test_fma_nan_resolver.sv
module test_fma_nan_resolver;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #10 clk = ~clk;

  logic        mode;
  logic [31:0] acc, ma, mb;
  logic        special;
  logic [31:0] result;
  logic        invalid;

  fma_nan_resolver i_fma_nan_resolver (
    .mode_i(mode), .acc_i(acc), .mul_a_i(ma), .mul_b_i(mb),
    .special_o(special), .result_o(result), .invalid_o(invalid)
  );

  localparam logic [31:0] ONE  = 32'h3F80_0000;
  localparam logic [31:0] PINF = 32'h7F80_0000;
  localparam logic [31:0] NINF = 32'hFF80_0000;
  localparam logic [31:0] PZ   = 32'h0000_0000;
  localparam logic [31:0] NZ   = 32'h8000_0000;
  localparam logic [31:0] DN   = 32'h7FC0_0000;
  localparam logic [31:0] Q1   = 32'h7FC0_0001;
  localparam logic [31:0] Q2   = 32'hFFC0_0002;
  localparam logic [31:0] Q3   = 32'h7FC0_0003;
  localparam logic [31:0] S1   = 32'h7F80_0011;
  localparam logic [31:0] S1Q  = 32'h7FC0_0011;
  localparam logic [31:0] S2   = 32'hFF80_0022;
  localparam logic [31:0] S2Q  = 32'hFFC0_0022;

  int total = 0;
  int fails = 0;
  bit done = 1'b0;

  task automatic run(input string tag, input logic m, input logic [31:0] c,
                     input logic [31:0] x, input logic [31:0] y,
                     input logic es, input logic [31:0] er, input logic ei);
    @(posedge clk);
    #1;
    mode = m; acc = c; ma = x; mb = y;
    @(negedge clk);
    total++;
    if (special !== es || result !== er || invalid !== ei) begin
      fails++;
      $display("FAIL %s: got special=%0b result=%08h invalid=%0b, expected special=%0b result=%08h invalid=%0b",
               tag, special, result, invalid, es, er, ei);
    end
  endtask

  task automatic t_idle;
    run("R1 reset state", 1'b0, PZ, PZ, PZ, 1'b0, 32'h0, 1'b0);
    run("R1 ordinary fused operands", 1'b0, 32'hBF80_0002, 32'h3F80_0001, 32'h3F80_0001, 1'b0, 32'h0, 1'b0);
    run("R1 ordinary mode1", 1'b1, ONE, ONE, ONE, 1'b0, 32'h0, 1'b0);
  endtask

  task automatic t_encoding;
    run("R8 inf times one", 1'b0, ONE, PINF, ONE, 1'b0, 32'h0, 1'b0);
    run("R8 zero times one plus inf", 1'b0, PINF, PZ, ONE, 1'b0, 32'h0, 1'b0);
    run("R8 inf acc zero product", 1'b1, NINF, NZ, ONE, 1'b0, 32'h0, 1'b0);
  endtask

  task automatic t_order_m0;
    run("R2 acc alone", 1'b0, Q1, ONE, ONE, 1'b1, Q1, 1'b0);
    run("R2 a alone", 1'b0, ONE, Q2, ONE, 1'b1, Q2, 1'b0);
    run("R2 b alone", 1'b0, ONE, ONE, Q3, 1'b1, Q3, 1'b0);
    run("R2 acc and a", 1'b0, Q1, Q2, ONE, 1'b1, Q1, 1'b0);
    run("R2 acc and b", 1'b0, Q1, ONE, Q3, 1'b1, Q1, 1'b0);
    run("R2 a and b", 1'b0, ONE, Q2, Q3, 1'b1, Q3, 1'b0);
    run("R2 all three", 1'b0, Q1, Q2, Q3, 1'b1, Q1, 1'b0);
  endtask

  task automatic t_order_m1;
    run("R3 acc alone", 1'b1, Q1, ONE, ONE, 1'b1, Q1, 1'b0);
    run("R3 acc and a", 1'b1, Q1, Q2, ONE, 1'b1, Q2, 1'b0);
    run("R3 acc and b", 1'b1, Q1, ONE, Q3, 1'b1, Q3, 1'b0);
    run("R3 a and b", 1'b1, ONE, Q2, Q3, 1'b1, Q2, 1'b0);
    run("R3 all three", 1'b1, Q1, Q2, Q3, 1'b1, Q2, 1'b0);
  endtask

  task automatic t_snan;
    run("R4 signalling acc quieted", 1'b0, S1, ONE, ONE, 1'b1, S1Q, 1'b1);
    run("R4 unselected signalling a", 1'b0, Q1, S2, ONE, 1'b1, Q1, 1'b1);
    run("R4 signalling a negative sign kept", 1'b0, ONE, S2, ONE, 1'b1, S2Q, 1'b1);
    run("R5 signalling acc passes", 1'b1, S1, ONE, ONE, 1'b1, S1, 1'b0);
    run("R5 signalling a wins unchanged", 1'b1, Q1, S2, ONE, 1'b1, S2, 1'b0);
  endtask

  task automatic t_inf_zero;
    run("R6 inf times zero mode0", 1'b0, ONE, PINF, PZ, 1'b1, DN, 1'b1);
    run("R6 zero times neg inf mode0", 1'b0, ONE, NZ, NINF, 1'b1, DN, 1'b1);
    run("R6 inf times zero mode1", 1'b1, ONE, PINF, PZ, 1'b1, DN, 1'b0);
    run("R7 signalling acc mode0", 1'b0, S1, PINF, PZ, 1'b1, S1Q, 1'b1);
    run("R7 signalling acc mode1", 1'b1, S1, PINF, PZ, 1'b1, S1, 1'b0);
    run("R7 quiet acc mode0", 1'b0, Q1, PZ, NINF, 1'b1, Q1, 1'b1);
    run("R7 quiet acc mode1", 1'b1, Q1, PINF, NZ, 1'b1, Q1, 1'b0);
  endtask

  initial begin
    mode = 1'b0; acc = '0; ma = '0; mb = '0;
    repeat (2) @(posedge clk);
    rst = 1'b0;
    t_idle();
    t_encoding();
    t_order_m0();
    t_order_m1();
    t_snan();
    t_inf_zero();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      total++;
      fails++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end
endmodule